// File: doc/BRIEF.md
# Dual-Channel PWM Plus Bit-Rate-Multiplier Static DAC

This block drives two single-bit DAC outputs. Each output becomes an analog level once it passes through an external RC low-pass filter. Each channel takes a 12-bit level split into two parts:

- An 8-bit pulse-width part sets how many clocks are high in every 256-clock frame.
- A 4-bit bit-rate-multiplier part picks frames, out of a repeating run of sixteen, that each get one extra high clock.

The extra clocks are spread evenly over the sixteen frames. The average duty therefore has 12-bit resolution, while the frame rate stays that of a plain 8-bit PWM.

Both channels share one frame counter and one sequence counter. Software writes each part through its own strobe and data bus. A written value waits in a holding register and becomes active only when a new sixteen-frame run begins. As a result, no run ever mixes old and new settings.

Top module: `pwmbrm_dac`

## Requirements
- R1: A frame lasts 256 clocks. With a zero fine value, the output is high for the first P clocks of every frame, where P is the coarse value, and low for the rest. The output is registered, so position k of a frame appears one clock after the counters reach k.
- R2: Frames of a run are numbered 1 to 16, with frame 1 starting at the first clock of the run. Fine bit 3 extends every odd frame (1, 3, 5, … 15) by one high clock.
- R3: Fine bit 2 extends frames 2, 6, 10 and 14 by one high clock.
- R4: Fine bit 1 extends frames 4 and 12, and fine bit 0 extends frame 8, each by one high clock.
- R5: When several fine bits are set, their frame sets combine. Over a full run the output is high for exactly 16·P + B clocks, where B is the fine value. Frame 16 is never extended.
- R6: A coarse value of 255 in an extended frame keeps the output high for all 256 clocks of that frame. A coarse value of 0 in an extended frame gives exactly one high clock.
- R7: A write that lands inside a run leaves the rest of that run unchanged. The new value applies from the first clock of the next run.
- R8: A write that lands on the last clock of a run applies from the very next run.
- R9: Each channel has its own write strobes. A write to one channel does not change the other channel's output.
- R10: Synchronous reset drives both outputs low and clears all values and counters. The first run starts on the first clock after reset is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwm_wr | input | 2 | Per-channel strobe for the coarse (pulse-width) value |
| pwm_wdata | input | 8 | Coarse value shared by both channels |
| brm_wr | input | 2 | Per-channel strobe for the fine (rate-multiplier) value |
| brm_wdata | input | 4 | Fine value shared by both channels |
| dac_out | output | 2 | Pulse outputs, one bit per channel |

## Verification
Two functions can fall in the same cycle: a register write and the run-boundary transfer from the holding register to the active setting. The bench waits until the counters sit on the final clock of a run and puts the write on exactly that edge. It then checks every sample of the following run against the new values, which shows that the write was neither lost nor deferred by a whole run. A second case writes mid-run and checks that the remainder of the current run still follows the old setting.

// File: rtl/pwmbrm_pkg.sv
package pwmbrm_pkg;

    localparam int PWM_W  = 8;
    localparam int BRM_W  = 4;
    localparam int NUM_CH = 2;
    localparam int FRAME_LEN = 1 << PWM_W;
    localparam int RUN_LEN   = 1 << BRM_W;

    typedef logic [PWM_W-1:0] pwm_t;
    typedef logic [BRM_W-1:0] brm_t;
    typedef logic [PWM_W:0]   duty_t;

    typedef struct packed {
        pwm_t pwm;
        brm_t brm;
    } setting_t;

    typedef struct packed {
        pwm_t pos;
        brm_t seq;
        logic last;
    } tbase_t;

    // Frame number is seq+1 (1..RUN_LEN, where RUN_LEN wraps to zero).
    // A frame whose number has k trailing zeros belongs to fine bit
    // BRM_W-1-k. The number zero (the final frame) belongs to no bit.
    function automatic logic frame_extended(brm_t seq, brm_t val);
        brm_t num;
        logic found;
        int   tz;
        logic hit;
        num   = seq + brm_t'(1);
        found = 1'b0;
        tz    = 0;
        hit   = 1'b0;
        for (int k = 0; k < BRM_W; k++) begin
            if (!found && num[k]) begin
                found = 1'b1;
                tz    = k;
            end
        end
        if (found) hit = val[BRM_W-1-tz];
        return hit;
    endfunction

endpackage

// File: rtl/pwmbrm_timebase.sv
module pwmbrm_timebase
    import pwmbrm_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    output tbase_t tb
);

    pwm_t pos_q;
    brm_t seq_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q <= '0;
            seq_q <= '0;
        end else begin
            pos_q <= pos_q + pwm_t'(1);
            if (pos_q == '1) seq_q <= seq_q + brm_t'(1);
        end
    end

    always_comb begin
        tb.pos  = pos_q;
        tb.seq  = seq_q;
        tb.last = (pos_q == '1) && (seq_q == '1);
    end

    // R1
    frame_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (pos_q == '1) |=> (pos_q == '0 && seq_q == brm_t'($past(seq_q) + brm_t'(1))));

    // R1
    seq_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (pos_q != '1) |=> $stable(seq_q));

endmodule

// File: rtl/pwmbrm_lane.sv
module pwmbrm_lane
    import pwmbrm_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  tbase_t tb,
    input  logic   pwm_wr,
    input  pwm_t   pwm_wdata,
    input  logic   brm_wr,
    input  brm_t   brm_wdata,
    output logic   dac_o
);

    setting_t pend_q, pend_nx, act_q;
    logic     extra;
    duty_t    duty;
    logic     dac_q;

    always_comb begin
        pend_nx = pend_q;
        if (pwm_wr) pend_nx.pwm = pwm_wdata;
        if (brm_wr) pend_nx.brm = brm_wdata;
    end

    always_comb begin
        extra = frame_extended(tb.seq, act_q.brm);
        duty  = {1'b0, act_q.pwm} + duty_t'(extra);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
            act_q  <= '0;
            dac_q  <= 1'b0;
        end else begin
            pend_q <= pend_nx;
            if (tb.last) act_q <= pend_nx;
            dac_q <= ({1'b0, tb.pos} < duty);
        end
    end

    assign dac_o = dac_q;

    // R7
    act_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !tb.last |=> $stable(act_q));

    // R8
    edge_write_chk: assert property (@(posedge clk) disable iff (rst)
        (tb.last && pwm_wr) |=> (act_q.pwm == $past(pwm_wdata)));

    // R5
    last_frame_chk: assert property (@(posedge clk) disable iff (rst)
        (tb.seq == '1) |-> !extra);

    // R5
    no_fine_chk: assert property (@(posedge clk) disable iff (rst)
        (act_q.brm == '0) |-> !extra);

    // R6
    full_on_chk: assert property (@(posedge clk) disable iff (rst)
        (act_q.pwm == '1 && extra) |=> dac_o);

    // R1
    idle_low_chk: assert property (@(posedge clk) disable iff (rst)
        (act_q == '0) |=> !dac_o);

endmodule

// File: rtl/pwmbrm_dac.sv
module pwmbrm_dac
    import pwmbrm_pkg::*;
#(
    parameter int CH = NUM_CH
)(
    input  logic             clk,
    input  logic             rst,
    input  logic [CH-1:0]    pwm_wr,
    input  logic [PWM_W-1:0] pwm_wdata,
    input  logic [CH-1:0]    brm_wr,
    input  logic [BRM_W-1:0] brm_wdata,
    output logic [CH-1:0]    dac_out
);

    tbase_t tb;

    pwmbrm_timebase i_timebase (
        .clk (clk),
        .rst (rst),
        .tb  (tb)
    );

    for (genvar c = 0; c < CH; c++) begin : g_lane
        pwmbrm_lane i_lane (
            .clk       (clk),
            .rst       (rst),
            .tb        (tb),
            .pwm_wr    (pwm_wr[c]),
            .pwm_wdata (pwm_wdata),
            .brm_wr    (brm_wr[c]),
            .brm_wdata (brm_wdata),
            .dac_o     (dac_out[c])
        );
    end

    // R10
    reset_low_chk: assert property (@(posedge clk)
        $past(rst) |-> (dac_out == '0));

endmodule

// File: tb/test_pwmbrm_dac.sv
module test_pwmbrm_dac;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] pwm_wr = '0;
    logic [7:0] pwm_wdata = '0;
    logic [1:0] brm_wr = '0;
    logic [3:0] brm_wdata = '0;
    logic [1:0] dac_out;

    int n_chk = 0;
    int n_bad = 0;
    int tcount = 0;
    bit done = 0;

    int pend_pwm [2];
    int pend_brm [2];
    int cur_pwm  [2];
    int cur_brm  [2];

    always #2 clk = ~clk;

    pwmbrm_dac i_pwmbrm_dac (
        .clk(clk), .rst(rst), .pwm_wr(pwm_wr), .pwm_wdata(pwm_wdata),
        .brm_wr(brm_wr), .brm_wdata(brm_wdata), .dac_out(dac_out)
    );

    always @(posedge clk) if (!rst) tcount <= tcount + 1;

    function automatic bit exp_hit(int f, int b);
        int n = f + 1;
        return (b[3] && (n % 2 == 1)) || (b[2] && (n % 4 == 2)) ||
               (b[1] && (n == 4 || n == 12)) || (b[0] && n == 8);
    endfunction

    function automatic bit exp_out(int t, int p, int b);
        int pos = (t - 1) % 256;
        int frm = ((t - 1) / 256) % 16;
        return pos < (p + int'(exp_hit(frm, b)));
    endfunction

    task automatic report(string req, bit ok, int act, int exp, int ch);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s ch%0d t=%0d actual=%0d expected=%0d", req, ch, tcount, act, exp);
        end
    endtask

    task automatic wr(int ch, bit dp, int p, bit db, int b);
        pwm_wr[ch] = dp; pwm_wdata = p[7:0];
        brm_wr[ch] = db; brm_wdata = b[3:0];
        if (dp) pend_pwm[ch] = p;
        if (db) pend_brm[ch] = b;
        @(negedge clk);
        pwm_wr = '0; brm_wr = '0;
    endtask

    task automatic commit();
        for (int c = 0; c < 2; c++) begin
            cur_pwm[c] = pend_pwm[c];
            cur_brm[c] = pend_brm[c];
        end
    endtask

    task automatic wait_boundary();
        do @(negedge clk); while (tcount % 4096 != 0);
    endtask

    task automatic check_window(int n, string r0, string r1);
        int errs [2] = '{0, 0};
        int hi   [2] = '{0, 0};
        int fa   [2] = '{0, 0};
        int fe   [2] = '{0, 0};
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            for (int c = 0; c < 2; c++) begin
                bit e = exp_out(tcount, cur_pwm[c], cur_brm[c]);
                if (dac_out[c]) hi[c]++;
                if (dac_out[c] !== e) begin
                    if (errs[c] == 0) begin fa[c] = int'(dac_out[c]); fe[c] = int'(e); end
                    errs[c]++;
                end
            end
        end
        report(r0, errs[0] == 0, fa[0], fe[0], 0);
        report(r1, errs[1] == 0, fa[1], fe[1], 1);
        if (n == 4096 && tcount % 4096 == 0) begin
            for (int c = 0; c < 2; c++)
                report("R5 high-count", hi[c] == 16 * cur_pwm[c] + cur_brm[c],
                       hi[c], 16 * cur_pwm[c] + cur_brm[c], c);
        end
    endtask

    task automatic t_reset();
        repeat (4) @(negedge clk);
        report("R10 reset", dac_out == 2'b00, int'(dac_out), 0, 0);
        rst = 1'b0;
        for (int c = 0; c < 2; c++) begin
            pend_pwm[c] = 0; pend_brm[c] = 0;
        end
        commit();
        check_window(4096, "R10", "R10");
    endtask

    task automatic t_coarse();
        wr(0, 1, 100, 1, 0);
        wr(1, 1, 37, 1, 0);
        wait_boundary(); commit();
        check_window(4096, "R1", "R1");
    endtask

    task automatic t_single_bits();
        wr(0, 1, 50, 1, 8);
        wr(1, 1, 50, 1, 4);
        wait_boundary(); commit();
        check_window(4096, "R2", "R3");
        wr(0, 1, 60, 1, 2);
        wr(1, 1, 90, 1, 1);
        wait_boundary(); commit();
        check_window(4096, "R4", "R4");
    endtask

    task automatic t_mixed();
        wr(0, 1, 10, 1, 15);
        wr(1, 1, 200, 1, 11);
        wait_boundary(); commit();
        check_window(4096, "R5", "R5");
    endtask

    task automatic t_extremes();
        wr(0, 1, 255, 1, 15);
        wr(1, 1, 0, 1, 15);
        wait_boundary(); commit();
        check_window(4096, "R6", "R6");
    endtask

    task automatic t_midrun();
        check_window(1998, "R7", "R7");
        wr(0, 1, 5, 1, 3);
        @(negedge clk);
        check_window(2096, "R7 old-run", "R7 old-run");
        commit();
        check_window(4096, "R7 new-run", "R9");
    endtask

    task automatic t_boundary_write();
        do @(negedge clk); while (tcount % 4096 != 4095);
        wr(1, 1, 77, 1, 5);
        commit();
        check_window(4096, "R9", "R8");
    endtask

    task automatic t_reset_again();
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        report("R10 re-reset", dac_out == 2'b00, int'(dac_out), 0, 0);
    endtask

    initial begin
        t_reset();
        t_coarse();
        t_single_bits();
        t_mixed();
        t_extremes();
        t_midrun();
        t_boundary_write();
        t_reset_again();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog t=%0d actual=running expected=finished", tcount);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule